// File: doc/BRIEF.md
# Signed Nine-Bit Arithmetic and Logic Unit

This block is a purely combinational arithmetic and logic unit. It takes two 9-bit operands and a 3-bit operation select, and produces an 18-bit result bus and five status flags. It has no clock, no reset and no internal state. It is meant to sit directly in a datapath wherever one cycle of combinational delay is acceptable.

Eight operations are supported:

- four bitwise operations, which treat the operands as raw bit patterns;
- three two's-complement operations: add, subtract and negate;
- one signed multiply.

Add, subtract and negate all share a single adder. A small mux in front of the adder picks its two inputs and its carry-in. Overflow is derived from the carries around the adder's top bit.

The status flags are sign, overflow, carry out, zero and operand equality.

Top module: `alu_signed9`

## Requirements
- R1: Codes 0, 1, 2 and 3 give A AND B, A OR B, A XOR B and NOT A on result bits 8:0, with bits 17:9 at zero.
- R2: Code 4 gives the low 9 bits of A + B. The carry flag is the carry out of the unsigned 9-bit sum.
- R3: Code 5 gives A − B, formed as A + NOT B + 1. The carry flag is the carry out of that sum, so it is 1 exactly when A ≥ B as unsigned values.
- R4: Code 6 gives −B, formed as 0 + NOT B + 1. The carry flag is 1 only when B is zero.
- R5: For codes 4, 5 and 6 the overflow flag is 1 exactly when the true signed result lies outside −256..255.
- R6: For codes 4, 5 and 6, result bits 17:9 all copy result bit 8 (sign extension).
- R7: Code 7 gives the signed product of A and B as an 18-bit two's-complement value.
- R8: The carry and overflow flags are 0 for codes 0–3 and for code 7.
- R9: The sign flag equals result bit 17 for code 7 and result bit 8 for every other code.
- R10: The zero flag is 1 exactly when all 18 result bits are 0.
- R11: The equal flag is 1 exactly when A equals B, whatever the operation code.
- R12: With A = 0x0FF and code 4:
  - B = 0x100 gives result bits 8:0 = 0x1FF with carry 0;
  - B = 0x101 gives 0x000 with carry 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 9 | First operand (A) |
| opb | input | 9 | Second operand (B) |
| opsel | input | 3 | Operation code, 0..7 |
| result | output | 18 | Selected result |
| flag_neg | output | 1 | Sign of the active result |
| flag_ovf | output | 1 | Signed overflow for codes 4–6 |
| flag_carry | output | 1 | Adder carry out for codes 4–6 |
| flag_zero | output | 1 | Result is all zeros |
| flag_eq | output | 1 | Operands are equal |

## Verification
The sweep covers every value of A. Each value of A is paired with a set of B values, and every operation code is applied to each pair.

The B set has two parts:

- Corner values: 0, 1, 0xFF, 0x100, 0x101 and 0x1FF. These separate the positive and negative overflow edges. They also separate the single negate case that produces a carry and the −256 negate case that overflows.
- A strided spread, which catches carry-chain and product bit errors in the middle bits.

Pairs with A equal to B show whether the equal flag ignores the opcode. Zero results from subtraction and from multiply by zero test the zero flag across all 18 bits.

// File: rtl/alu_signed9_pkg.sv
package alu_signed9_pkg;
    typedef enum logic [2:0] {
        OP_AND = 3'd0,
        OP_OR  = 3'd1,
        OP_XOR = 3'd2,
        OP_INV = 3'd3,
        OP_ADD = 3'd4,
        OP_SUB = 3'd5,
        OP_NEG = 3'd6,
        OP_MUL = 3'd7
    } alu_op_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 9
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         c_msb
);
    logic [W-1:0] low;
    logic [1:0]   top;

    // Low part: carry out of bit W-2 lands in low[W-1]
    assign low   = {1'b0, x[W-2:0]} + {1'b0, y[W-2:0]} + {{(W-1){1'b0}}, cin};
    assign c_msb = low[W-1];
    assign top   = {1'b0, x[W-1]} + {1'b0, y[W-1]} + {1'b0, c_msb};
    assign sum   = {top[0], low[W-2:0]};
    assign cout  = top[1];
endmodule

// File: rtl/alu_mult.sv
module alu_mult #(
    parameter int W = 9
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] prod
);
    logic signed [2*W-1:0] ax;
    logic signed [2*W-1:0] bx;

    assign ax   = {{W{a[W-1]}}, a};
    assign bx   = {{W{b[W-1]}}, b};
    assign prod = ax * bx;
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
    parameter int W = 9
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   fn,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (fn)
            2'd0: y = a & b;
            2'd1: y = a | b;
            2'd2: y = a ^ b;
            default: y = ~a;
        endcase
    end
endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
    parameter int W = 9
) (
    input  logic [2*W-1:0] res,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           is_arith,
    input  logic           is_mul,
    input  logic           cout,
    input  logic           c_msb,
    output logic           neg,
    output logic           ovf,
    output logic           carry,
    output logic           zero,
    output logic           eq
);
    assign neg   = is_mul ? res[2*W-1] : res[W-1];
    assign ovf   = is_arith & (c_msb ^ cout);
    assign carry = is_arith & cout;
    assign zero  = (res == '0);
    assign eq    = (a == b);
endmodule

// File: rtl/alu_signed9.sv
module alu_signed9
    import alu_signed9_pkg::*;
#(
    parameter int W = 9,
    localparam int RW = 2 * W
) (
    input  logic [W-1:0]  opa,
    input  logic [W-1:0]  opb,
    input  logic [2:0]    opsel,
    output logic [RW-1:0] result,
    output logic          flag_neg,
    output logic          flag_ovf,
    output logic          flag_carry,
    output logic          flag_zero,
    output logic          flag_eq
);
    alu_op_e      op;
    logic         is_arith;
    logic         is_mul;
    logic [W-1:0] add_x;
    logic [W-1:0] add_y;
    logic         add_cin;
    logic [W-1:0] add_sum;
    logic         add_cout;
    logic         add_cmsb;
    logic [W-1:0] log_y;
    logic [RW-1:0] mul_p;

    assign op       = alu_op_e'(opsel);
    assign is_mul   = (op == OP_MUL);
    assign is_arith = (op == OP_ADD) || (op == OP_SUB) || (op == OP_NEG);

    // Operand steering for the shared adder
    always_comb begin
        unique case (op)
            OP_ADD:  begin add_x = opa; add_y = opb;  add_cin = 1'b0; end
            OP_SUB:  begin add_x = opa; add_y = ~opb; add_cin = 1'b1; end
            OP_NEG:  begin add_x = '0;  add_y = ~opb; add_cin = 1'b1; end
            default: begin add_x = opa; add_y = opb;  add_cin = 1'b0; end
        endcase
    end

    alu_addsub #(.W(W)) u_add (
        .x(add_x), .y(add_y), .cin(add_cin),
        .sum(add_sum), .cout(add_cout), .c_msb(add_cmsb)
    );

    alu_logic #(.W(W)) u_logic (
        .a(opa), .b(opb), .fn(opsel[1:0]), .y(log_y)
    );

    alu_mult #(.W(W)) u_mul (
        .a(opa), .b(opb), .prod(mul_p)
    );

    // Result selection
    always_comb begin
        if (is_mul)
            result = mul_p;
        else if (is_arith)
            result = {{(RW-W){add_sum[W-1]}}, add_sum};
        else
            result = {{(RW-W){1'b0}}, log_y};
    end

    alu_flags #(.W(W)) u_flags (
        .res(result), .a(opa), .b(opb),
        .is_arith(is_arith), .is_mul(is_mul),
        .cout(add_cout), .c_msb(add_cmsb),
        .neg(flag_neg), .ovf(flag_ovf), .carry(flag_carry),
        .zero(flag_zero), .eq(flag_eq)
    );
endmodule

// File: rtl/alu_signed9_checker.sv
module alu_signed9_checker #(
    parameter int W = 9,
    localparam int RW = 2 * W
) (
    input logic [W-1:0]  opa,
    input logic [W-1:0]  opb,
    input logic [2:0]    opsel,
    input logic [RW-1:0] result,
    input logic          flag_neg,
    input logic          flag_ovf,
    input logic          flag_carry,
    input logic          flag_zero,
    input logic          flag_eq
);
    logic signed [RW-1:0] sa;
    logic signed [RW-1:0] sb;
    logic        [W:0]    usum;

    assign sa   = {{W{opa[W-1]}}, opa};
    assign sb   = {{W{opb[W-1]}}, opb};
    assign usum = {1'b0, opa} + {1'b0, opb};

    always_comb begin
        if (opsel < 3'd4) begin
            p_logic_upper_zero_r1: assert (result[RW-1:W] == '0);
        end
        if (opsel == 3'd4) begin
            p_add_sum_r2: assert (result[W-1:0] == usum[W-1:0] && flag_carry == usum[W]);
        end
        if (opsel inside {3'd4, 3'd5, 3'd6}) begin
            p_sign_ext_r6: assert (result[RW-1:W] == {(RW-W){result[W-1]}});
        end
        if (opsel == 3'd7) begin
            p_product_r7: assert ($signed(result) == sa * sb);
        end
        if (opsel < 3'd4 || opsel == 3'd7) begin
            p_no_flags_r8: assert (!flag_carry && !flag_ovf);
        end
        p_neg_bit_r9: assert (flag_neg == ((opsel == 3'd7) ? result[RW-1] : result[W-1]));
        p_zero_r10: assert (flag_zero == (result == '0));
        p_equal_r11: assert (flag_eq == (opa == opb));
    end
endmodule

bind alu_signed9 alu_signed9_checker #(.W(W)) u_chk (.*);

// File: tb/alu_signed9_test.sv
module alu_signed9_test;
    logic        clk = 1'b0;
    logic [8:0]  opa = '0;
    logic [8:0]  opb = '0;
    logic [2:0]  opsel = '0;
    logic [17:0] result;
    logic        flag_neg, flag_ovf, flag_carry, flag_zero, flag_eq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    alu_signed9 uut (
        .opa(opa), .opb(opb), .opsel(opsel), .result(result),
        .flag_neg(flag_neg), .flag_ovf(flag_ovf), .flag_carry(flag_carry),
        .flag_zero(flag_zero), .flag_eq(flag_eq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h",
                     req, opsel, opa, opb, act, exp);
        end
    endtask

    task automatic apply(input int a, input int b, input int op);
        int sa, sb, s, low, cy, ov, res, nb;
        opa = a[8:0]; opb = b[8:0]; opsel = op[2:0];
        #1;
        sa = (a >= 256) ? a - 512 : a;
        sb = (b >= 256) ? b - 512 : b;
        nb = (~b) & 511;
        cy = 0; ov = 0; s = 0;
        case (op)
            0: res = a & b;
            1: res = a | b;
            2: res = a ^ b;
            3: res = (~a) & 511;
            4: begin s = sa + sb; cy = (a + b) >> 9; end
            5: begin s = sa - sb; cy = (a + nb + 1) >> 9; end
            6: begin s = -sb;     cy = (nb + 1) >> 9; end
            default: res = (sa * sb) & 32'h3FFFF;
        endcase
        if (op >= 4 && op <= 6) begin
            ov  = (s > 255 || s < -256) ? 1 : 0;
            low = s & 511;
            res = (low >= 256) ? (low | 32'h3FE00) : low;
        end
        if (op < 4)       chk("R1", int'(result), res);
        else if (op == 4) chk("R2", int'(result), res);
        else if (op == 5) chk("R3", int'(result), res);
        else if (op == 6) chk("R4", int'(result), res);
        else              chk("R7", int'(result), res);
        if (op >= 4 && op <= 6) begin
            chk("R5", int'(flag_ovf), ov);
            chk("R6", int'(result[17:9]), (res >> 9) & 511);
            chk("R2/R3/R4 carry", int'(flag_carry), cy);
        end else begin
            chk("R8", int'({flag_carry, flag_ovf}), 0);
        end
        chk("R9", int'(flag_neg), (op == 7) ? ((res >> 17) & 1) : ((res >> 8) & 1));
        chk("R10", int'(flag_zero), (res == 0) ? 1 : 0);
        chk("R11", int'(flag_eq), (a == b) ? 1 : 0);
        #1;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        int corners[6] = '{0, 1, 255, 256, 257, 511};
        #3;
        // Reset-state (all-zero inputs): AND of zeros
        chk("R10", int'(flag_zero), 1);
        chk("R11", int'(flag_eq), 1);
        // R12 worked examples
        apply(255, 256, 4);
        chk("R12", int'(result[8:0]), 511);
        chk("R12", int'(flag_carry), 0);
        apply(255, 257, 4);
        chk("R12", int'(result[8:0]), 0);
        chk("R12", int'(flag_carry), 1);
        for (int a = 0; a < 512; a++) begin
            for (int k = 0; k < 6; k++)
                for (int op = 0; op < 8; op++)
                    apply(a, corners[k], op);
            for (int b = 3; b < 512; b += 41)
                for (int op = 0; op < 8; op++)
                    apply(a, b, op);
            for (int op = 0; op < 8; op++)
                apply(a, a, op);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule